// File: doc/BRIEF.md
# Inclusive Coherence Directory with Snoop Filtering

This block is the directory controller that sits at the shared last level of a small multicore, six cores by default. For every tracked line it keeps a coherence state (Invalid, Shared, Exclusive or Modified), a presence vector with one bit per core, and a flag that says whether the shared level's own data copy of the line is current. The private caches send it read requests and read-for-ownership requests. For each request it decides on one of four actions: answer from the shared copy, fetch the line from memory, invalidate the other sharers, or snoop the single owning core.

The tags are inclusive, so they act as a snoop filter. The directory keeps track of a private owner even after its own data copy has gone stale. Snoops therefore reach only the cores that are known to hold the line, and memory is read only when the directory does not track the line at all. When a Modified line is downgraded by another core's read, the owner's dirty data is copied into the shared level and written to memory. Requests are handled one at a time: `req_ready` is high only while the controller is idle.

The controller is one state machine with these states. IDLE accepts a request (IDLE→LOOKUP). LOOKUP reads the entry and branches: to MEMRD on a miss, to SNPSEND when some other core must be contacted, otherwise straight to RESP. MEMRD waits for the memory acknowledge and then goes to RESP. SNPSEND sends a one-cycle snoop pulse to every target core (SNPSEND→SNPWAIT). SNPWAIT stays until every target has acknowledged. It then goes to MEMWB if a read collected dirty data, otherwise to RESP. MEMWB waits for the memory write acknowledge and then goes to RESP. RESP issues the response, updates the entry and returns to IDLE.

Top module: `coh_snoop_dir`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid`, `mem_req` and every bit of `snp_valid` are 0.
- R2: A request to an untracked line issues exactly one memory read (`mem_we`=0) of that line and no snoop. It is answered with the memory data. The grant is Exclusive (code 2) for a read (`req_rfo`=0) and Modified (code 3) for a read-for-ownership (`req_rfo`=1).
- R3: A read of a Shared line (code 1) is answered from the shared copy with grant Shared. No snoop and no memory access take place.
- R4: A read-for-ownership of a Shared line sends an invalidate (`snp_inv`=1) to exactly the holders other than the requester. The grant is Modified with the current data, and there is no memory access.
- R5: A read of a line that another core owns (Exclusive or Modified) sends a downgrade (`snp_inv`=0) to that owner only. The grant is Shared and no memory read is issued. The data is the owner's acknowledge data if it was dirty, otherwise the shared copy.
- R6: A downgrade that returns dirty data causes exactly one memory write of that data to the line. A clean downgrade causes no memory write.
- R7: A read-for-ownership of a line that another core owns invalidates that owner only and passes on the owner's dirty data. The grant is Modified and there is no memory access.
- R8: After ownership has moved by read-for-ownership, the shared copy is stale. A later read of the line is still served by snooping the tracked owner, not by memory.
- R9: A request from the core that already owns the line is answered without snoop or memory access. A read keeps the held grant, and a read-for-ownership grants Modified.
- R10: Only one request is in flight. `req_ready` stays 0 from acceptance until the response. A response is issued only after every targeted core has acknowledged.
- R11: At most one core holds a line Exclusive or Modified, and it is then the only holder. Every downgrade snoop targets exactly one core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_core | input | CW | Requesting core index |
| req_rfo | input | 1 | 1 = read-for-ownership, 0 = read |
| req_line | input | LW | Line index |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_core | output | CW | Core the response is for |
| rsp_grant | output | 2 | Granted state: 0 I, 1 S, 2 E, 3 M |
| rsp_data | output | DW | Line data |
| snp_valid | output | NC | One-cycle snoop pulse per target core |
| snp_inv | output | 1 | 1 = invalidate, 0 = downgrade to Shared |
| snp_line | output | LW | Line being snooped |
| ack_valid | input | 1 | Snoop acknowledge from one core |
| ack_core | input | CW | Acknowledging core |
| ack_dirty | input | 1 | Acknowledge carries modified data |
| ack_data | input | DW | Data from the acknowledging core |
| mem_req | output | 1 | Memory access held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_line | output | LW | Memory line index |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |

## Verification
The assertions take for granted that an acknowledge comes only from a core that is still being waited on, and that each core acknowledges at most once per snoop round. They also assume that memory raises `mem_ack` only while `mem_req` is high, and that no core asks for ownership of a line it already holds Shared alone without going through the directory. The bench models each core's private state and acknowledges one pending target per cycle, starting with the lowest index, so acknowledges never repeat or go to an idle core. Its memory model answers one cycle after a request. Its scenarios issue requests only after the previous response, and they perform silent writes only on lines the model holds Exclusive or Modified.

// File: rtl/cdir_pkg.sv
package cdir_pkg;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } lstate_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_MEMRD,
        ST_SNPSEND,
        ST_SNPWAIT,
        ST_MEMWB,
        ST_RESP
    } fsm_e;

endpackage

// File: rtl/cdir_meta_store.sv
module cdir_meta_store
    import cdir_pkg::*;
#(
    parameter int NC = 6,
    parameter int NL = 16,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_line,
    output lstate_e       rd_state,
    output logic [NC-1:0] rd_pres,
    output logic          rd_dv,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_line,
    input  lstate_e       wr_state,
    input  logic [NC-1:0] wr_pres,
    input  logic          wr_dv
);

    lstate_e       st_r [NL];
    logic [NC-1:0] pr_r [NL];
    logic          dv_r [NL];

    for (genvar g = 0; g < NL; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_r[g] <= LS_I;
                pr_r[g] <= '0;
                dv_r[g] <= 1'b0;
            end else if (wr_en && wr_line == LW'(g)) begin
                st_r[g] <= wr_state;
                pr_r[g] <= wr_pres;
                dv_r[g] <= wr_dv;
            end
        end
    end

    assign rd_state = st_r[rd_line];
    assign rd_pres  = pr_r[rd_line];
    assign rd_dv    = dv_r[rd_line];

    // An owner state always carries exactly one presence bit
    p_owner_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_state == LS_E || wr_state == LS_M)) |-> $onehot(wr_pres));

    // A tracked line has at least one holder; an untracked one has none
    p_pres_matches_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((wr_state == LS_I) == (wr_pres == '0)));

endmodule

// File: rtl/cdir_data_store.sv
module cdir_data_store #(
    parameter int NL = 16,
    parameter int DW = 32,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] rd_line,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_line,
    input  logic [DW-1:0] wr_data
);

    logic [DW-1:0] mem_r [NL];

    for (genvar g = 0; g < NL; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem_r[g] <= '0;
            else if (wr_en && wr_line == LW'(g))
                mem_r[g] <= wr_data;
        end
    end

    assign rd_data = mem_r[rd_line];

endmodule

// File: rtl/cdir_ack_gather.sv
module cdir_ack_gather #(
    parameter int NC = 6,
    parameter int DW = 32,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NC-1:0] load_mask,
    input  logic          ack_valid,
    input  logic [CW-1:0] ack_core,
    input  logic          ack_dirty,
    input  logic [DW-1:0] ack_data,
    output logic [NC-1:0] pending,
    output logic          dirty_seen,
    output logic [DW-1:0] dirty_data
);

    logic [NC-1:0] ack_bit;
    assign ack_bit = NC'(1) << ack_core;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending    <= '0;
            dirty_seen <= 1'b0;
            dirty_data <= '0;
        end else if (load) begin
            pending    <= load_mask;
            dirty_seen <= 1'b0;
        end else if (ack_valid) begin
            pending <= pending & ~ack_bit;
            if (ack_dirty) begin
                dirty_seen <= 1'b1;
                dirty_data <= ack_data;
            end
        end
    end

    // Acknowledges arrive only from cores still being waited on
    p_ack_expected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (pending & ack_bit) != '0);

    // The pending set only shrinks between loads
    p_pending_shrinks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (pending & ~$past(pending)) == '0);

endmodule

// File: rtl/coh_snoop_dir.sv
module coh_snoop_dir
    import cdir_pkg::*;
#(
    parameter int NC = 6,
    parameter int NL = 16,
    parameter int DW = 32,
    localparam int CW = (NC > 1) ? $clog2(NC) : 1,
    localparam int LW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_core,
    input  logic          req_rfo,
    input  logic [LW-1:0] req_line,
    output logic          rsp_valid,
    output logic [CW-1:0] rsp_core,
    output logic [1:0]    rsp_grant,
    output logic [DW-1:0] rsp_data,
    output logic [NC-1:0] snp_valid,
    output logic          snp_inv,
    output logic [LW-1:0] snp_line,
    input  logic          ack_valid,
    input  logic [CW-1:0] ack_core,
    input  logic          ack_dirty,
    input  logic [DW-1:0] ack_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [LW-1:0] mem_line,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    fsm_e          st, st_nxt;
    logic [CW-1:0] q_core;
    logic          q_rfo;
    logic [LW-1:0] q_line;
    logic [NC-1:0] tgt_q;
    logic          inv_q;
    logic [DW-1:0] fill_q;

    lstate_e       rd_state;
    logic [NC-1:0] rd_pres;
    logic          rd_dv;
    logic [DW-1:0] sh_data;

    lstate_e       n_state;
    logic [NC-1:0] n_pres;
    logic          n_dv;
    logic          wd_en;
    logic [DW-1:0] wd_data;
    lstate_e       grant;
    logic [DW-1:0] out_data;

    logic [NC-1:0] pending;
    logic          dirty_seen;
    logic [DW-1:0] dirty_data;

    logic [NC-1:0] req_bit;
    logic          hit;
    logic          owner_is_req;
    logic [NC-1:0] tgt;
    logic          gather_load;

    assign req_bit      = NC'(1) << q_core;
    assign hit          = (rd_state != LS_I);
    assign owner_is_req = (rd_state == LS_E || rd_state == LS_M) && rd_pres[q_core];

    // Snoop target selection from the looked-up entry
    always_comb begin
        tgt = '0;
        if (hit) begin
            if (rd_state == LS_S)
                tgt = q_rfo ? (rd_pres & ~req_bit) : '0;
            else
                tgt = owner_is_req ? '0 : rd_pres;
        end
    end

    assign gather_load = (st == ST_LOOKUP) && hit && (tgt != '0);

    cdir_meta_store #(.NC(NC), .NL(NL)) meta_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_line  (q_line),
        .rd_state (rd_state),
        .rd_pres  (rd_pres),
        .rd_dv    (rd_dv),
        .wr_en    (st == ST_RESP),
        .wr_line  (q_line),
        .wr_state (n_state),
        .wr_pres  (n_pres),
        .wr_dv    (n_dv)
    );

    cdir_data_store #(.NL(NL), .DW(DW)) data_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (q_line),
        .rd_data (sh_data),
        .wr_en   ((st == ST_RESP) && wd_en),
        .wr_line (q_line),
        .wr_data (wd_data)
    );

    cdir_ack_gather #(.NC(NC), .DW(DW)) gather_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (gather_load),
        .load_mask  (tgt),
        .ack_valid  (ack_valid),
        .ack_core   (ack_core),
        .ack_dirty  (ack_dirty),
        .ack_data   (ack_data),
        .pending    (pending),
        .dirty_seen (dirty_seen),
        .dirty_data (dirty_data)
    );

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            q_core <= '0;
            q_rfo  <= 1'b0;
            q_line <= '0;
            tgt_q  <= '0;
            inv_q  <= 1'b0;
            fill_q <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE && req_valid) begin
                q_core <= req_core;
                q_rfo  <= req_rfo;
                q_line <= req_line;
            end
            if (st == ST_LOOKUP) begin
                tgt_q <= tgt;
                inv_q <= q_rfo;
            end
            if (st == ST_MEMRD && mem_ack)
                fill_q <= mem_rdata;
        end
    end

    // Transitions
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:    if (req_valid) st_nxt = ST_LOOKUP;
            ST_LOOKUP: begin
                if (!hit)              st_nxt = ST_MEMRD;
                else if (tgt != '0)    st_nxt = ST_SNPSEND;
                else                   st_nxt = ST_RESP;
            end
            ST_MEMRD:   if (mem_ack) st_nxt = ST_RESP;
            ST_SNPSEND: st_nxt = ST_SNPWAIT;
            ST_SNPWAIT: begin
                if (pending == '0)
                    st_nxt = (!q_rfo && dirty_seen) ? ST_MEMWB : ST_RESP;
            end
            ST_MEMWB:   if (mem_ack) st_nxt = ST_RESP;
            ST_RESP:    st_nxt = ST_IDLE;
            default:    st_nxt = ST_IDLE;
        endcase
    end

    // Entry update, grant and response data for the RESP state
    always_comb begin
        n_state  = rd_state;
        n_pres   = rd_pres;
        n_dv     = rd_dv;
        grant    = rd_state;
        wd_en    = 1'b0;
        wd_data  = fill_q;
        out_data = sh_data;
        if (rd_state == LS_I) begin
            grant    = q_rfo ? LS_M : LS_E;
            n_state  = grant;
            n_pres   = req_bit;
            n_dv     = !q_rfo;
            wd_en    = 1'b1;
            out_data = fill_q;
        end else if (rd_state == LS_S) begin
            if (q_rfo) begin
                grant   = LS_M;
                n_state = LS_M;
                n_pres  = req_bit;
                n_dv    = 1'b0;
            end else begin
                grant   = LS_S;
                n_pres  = rd_pres | req_bit;
            end
        end else if (owner_is_req) begin
            if (q_rfo) n_state = LS_M;
            grant = q_rfo ? LS_M : rd_state;
        end else begin
            if (q_rfo) begin
                grant   = LS_M;
                n_state = LS_M;
                n_pres  = req_bit;
                n_dv    = 1'b0;
            end else begin
                grant   = LS_S;
                n_state = LS_S;
                n_pres  = rd_pres | req_bit;
                n_dv    = 1'b1;
                wd_en   = dirty_seen;
                wd_data = dirty_data;
            end
            if (dirty_seen) out_data = dirty_data;
        end
    end

    // Port outputs by state
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        snp_valid = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        unique case (st)
            ST_IDLE:    req_ready = 1'b1;
            ST_LOOKUP:  ;
            ST_MEMRD:   mem_req = 1'b1;
            ST_SNPSEND: snp_valid = tgt_q;
            ST_SNPWAIT: ;
            ST_MEMWB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            ST_RESP:    rsp_valid = 1'b1;
            default:    ;
        endcase
    end

    assign rsp_core  = q_core;
    assign rsp_grant = grant;
    assign rsp_data  = out_data;
    assign snp_inv   = inv_q;
    assign snp_line  = q_line;
    assign mem_line  = q_line;
    assign mem_wdata = dirty_data;

    // Assertions
    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_after_acks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (pending == '0));

    p_ready_after_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    p_no_self_snoop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid != '0) |-> !snp_valid[q_core]);

    p_downgrade_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_valid != '0) && !snp_inv) |-> $onehot(snp_valid));

    p_grant_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_grant != 2'd0));

    p_mem_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line) && $stable(mem_we)));

    p_shared_copy_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOKUP && rd_state == LS_S) |-> rd_dv);

endmodule

// File: tb/coh_snoop_dir_tb_top.sv
`timescale 1ns/1ps
module coh_snoop_dir_tb_top;

    localparam int NC = 6;
    localparam int NL = 16;
    localparam int DW = 32;
    localparam int CW = 3;
    localparam int LW = 4;
    localparam int G_I = 0, G_S = 1, G_E = 2, G_M = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [CW-1:0] req_core = '0;
    logic          req_rfo = 1'b0;
    logic [LW-1:0] req_line = '0;
    logic          rsp_valid;
    logic [CW-1:0] rsp_core;
    logic [1:0]    rsp_grant;
    logic [DW-1:0] rsp_data;
    logic [NC-1:0] snp_valid;
    logic          snp_inv;
    logic [LW-1:0] snp_line;
    logic          ack_valid = 1'b0;
    logic [CW-1:0] ack_core = '0;
    logic          ack_dirty = 1'b0;
    logic [DW-1:0] ack_data = '0;
    logic          mem_req;
    logic          mem_we;
    logic [LW-1:0] mem_line;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    coh_snoop_dir #(.NC(NC), .NL(NL), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_core(req_core),
        .req_rfo(req_rfo), .req_line(req_line),
        .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_grant(rsp_grant),
        .rsp_data(rsp_data),
        .snp_valid(snp_valid), .snp_inv(snp_inv), .snp_line(snp_line),
        .ack_valid(ack_valid), .ack_core(ack_core), .ack_dirty(ack_dirty),
        .ack_data(ack_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_line(mem_line),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Reference state
    int          cst [NC][NL];
    logic [31:0] cd  [NC][NL];
    logic [31:0] mem_m [NL];

    int          total = 0;
    int          bad = 0;
    logic [NC-1:0] pend = '0;
    logic [NC-1:0] seen_mask = '0;
    logic          seen_inv = 1'b0;
    logic [LW-1:0] snp_l = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_wr = '0;
    logic [1:0]  got_g;
    logic [31:0] got_d;
    bit          early;
    logic [NC-1:0] pend_at_rsp;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cores and memory: respond on the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem_m[mem_line] = mem_wdata;
                    last_wr = mem_wdata;
                    wr_cnt++;
                end else begin
                    mem_rdata = mem_m[mem_line];
                    rd_cnt++;
                end
            end
            if (snp_valid != '0) begin
                pend      = pend | snp_valid;
                seen_mask = seen_mask | snp_valid;
                seen_inv  = snp_inv;
                snp_l     = snp_line;
            end
            ack_valid = 1'b0;
            if (pend != '0) begin
                for (int k = 0; k < NC; k++) begin
                    if (pend[k] && !ack_valid) begin
                        ack_valid = 1'b1;
                        ack_core  = CW'(k);
                        ack_dirty = (cst[k][snp_l] == G_M);
                        ack_data  = cd[k][snp_l];
                        cst[k][snp_l] = seen_inv ? G_I : G_S;
                        pend[k] = 1'b0;
                    end
                end
            end
        end
    end

    task automatic issue(input int c, input bit rfo, input int l);
        int n;
        seen_mask = '0; rd_cnt = 0; wr_cnt = 0; early = 0;
        @(negedge clk);
        req_valid = 1'b1; req_core = CW'(c); req_rfo = rfo; req_line = LW'(l);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!rsp_valid && n < 200) begin
            if (req_ready) early = 1;
            @(negedge clk);
            n++;
        end
        chk(rsp_valid, "R10", "response arrives", 32'(rsp_valid), 1);
        chk(!early, "R10", "ready stays low in flight", 32'(early), 0);
        chk(rsp_core == CW'(c), "R10", "response core", 32'(rsp_core), 32'(c));
        got_g = rsp_grant;
        got_d = rsp_data;
        pend_at_rsp = pend;
        chk(pend_at_rsp == '0, "R10", "all acks before response", 32'(pend_at_rsp), 0);
        cst[c][l] = int'(got_g);
        cd[c][l]  = got_d;
        @(negedge clk);
    endtask

    task automatic single_writer(input int l);
        int own = 0, held = 0;
        for (int k = 0; k < NC; k++) begin
            if (cst[k][l] == G_E || cst[k][l] == G_M) own++;
            if (cst[k][l] != G_I) held++;
        end
        chk(own <= 1 && (own == 0 || held == 1), "R11", "single writer",
            32'(held), 32'(own));
    endtask

    function automatic logic [NC-1:0] holders_but(input int c, input int l);
        logic [NC-1:0] m = '0;
        for (int k = 0; k < NC; k++)
            if (k != c && cst[k][l] != G_I) m[k] = 1'b1;
        return m;
    endfunction

    task automatic silent_write(input int c, input int l, input logic [31:0] v);
        cst[c][l] = G_M;
        cd[c][l]  = v;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
        chk(!rsp_valid && !mem_req && snp_valid == '0, "R1", "quiet after reset",
            {rsp_valid, mem_req, 24'(snp_valid)}, 0);
    endtask

    task automatic t_read_miss();
        issue(0, 0, 3);
        chk(got_g == 2'(G_E), "R2", "read miss grant", 32'(got_g), G_E);
        chk(got_d == mem_m[3], "R2", "read miss data", got_d, mem_m[3]);
        chk(rd_cnt == 1 && wr_cnt == 0, "R2", "one memory read", rd_cnt, 1);
        chk(seen_mask == '0, "R2", "no snoop on miss", 32'(seen_mask), 0);
        single_writer(3);
    endtask

    task automatic t_read_dirty_owner();
        logic [NC-1:0] exp_m;
        silent_write(0, 3, 32'd200);
        exp_m = holders_but(4, 3);
        issue(4, 0, 3);
        chk(seen_mask == exp_m && !seen_inv, "R5", "downgrade only owner",
            32'(seen_mask), 32'(exp_m));
        chk(got_g == 2'(G_S) && got_d == 32'd200, "R5", "shared grant with owner data",
            got_d, 200);
        chk(rd_cnt == 0, "R5", "no memory read", rd_cnt, 0);
        chk(wr_cnt == 1 && mem_m[3] == 32'd200, "R6", "dirty written to memory",
            mem_m[3], 200);
        chk(cst[0][3] == G_S, "R5", "owner now shared", cst[0][3], G_S);
        single_writer(3);
    endtask

    task automatic t_shared_hit();
        issue(5, 0, 3);
        chk(got_g == 2'(G_S) && got_d == 32'd200, "R3", "shared hit data", got_d, 200);
        chk(seen_mask == '0 && rd_cnt == 0 && wr_cnt == 0, "R3", "no traffic on hit",
            32'(seen_mask) + 32'(rd_cnt) + 32'(wr_cnt), 0);
        single_writer(3);
    endtask

    task automatic t_rfo_shared();
        logic [NC-1:0] exp_m;
        exp_m = holders_but(5, 3);
        issue(5, 1, 3);
        chk(seen_mask == exp_m && seen_inv, "R4", "invalidate other holders",
            32'(seen_mask), 32'(exp_m));
        chk(got_g == 2'(G_M) && got_d == 32'd200, "R4", "modified grant", got_d, 200);
        chk(rd_cnt == 0 && wr_cnt == 0, "R4", "no memory access", rd_cnt + wr_cnt, 0);
        single_writer(3);
    endtask

    task automatic t_read_after_transfer();
        silent_write(5, 3, 32'd300);
        issue(0, 0, 3);
        chk(seen_mask == 6'b100000, "R8", "stale copy still snoops owner",
            32'(seen_mask), 32'h20);
        chk(got_d == 32'd300 && rd_cnt == 0, "R8", "owner data, no memory read",
            got_d, 300);
        chk(wr_cnt == 1 && last_wr == 32'd300, "R6", "writeback of new data",
            last_wr, 300);
        single_writer(3);
    endtask

    task automatic t_rfo_miss_and_owned();
        issue(2, 1, 7);
        chk(got_g == 2'(G_M) && got_d == mem_m[7], "R2", "rfo miss grant", 32'(got_g), G_M);
        chk(rd_cnt == 1, "R2", "rfo miss reads memory", rd_cnt, 1);
        silent_write(2, 7, 32'd777);
        issue(1, 1, 7);
        chk(seen_mask == 6'b000100 && seen_inv, "R7", "invalidate owner only",
            32'(seen_mask), 32'h4);
        chk(got_g == 2'(G_M) && got_d == 32'd777, "R7", "owner data passed", got_d, 777);
        chk(rd_cnt == 0 && wr_cnt == 0, "R7", "no memory access", rd_cnt + wr_cnt, 0);
        single_writer(7);
    endtask

    task automatic t_owner_rerequest();
        issue(1, 0, 7);
        chk(got_g == 2'(G_M), "R9", "owner read keeps grant", 32'(got_g), G_M);
        chk(seen_mask == '0 && rd_cnt == 0 && wr_cnt == 0, "R9", "owner read no traffic",
            32'(seen_mask), 0);
        issue(3, 0, 9);
        issue(3, 1, 9);
        chk(got_g == 2'(G_M), "R9", "owner rfo grants modified", 32'(got_g), G_M);
        chk(seen_mask == '0 && rd_cnt == 0, "R9", "owner rfo no traffic", rd_cnt, 0);
        single_writer(9);
    endtask

    task automatic t_clean_downgrade();
        issue(2, 0, 11);
        issue(4, 0, 11);
        chk(seen_mask == 6'b000100 && !seen_inv, "R5", "clean owner downgraded",
            32'(seen_mask), 32'h4);
        chk(got_g == 2'(G_S) && got_d == mem_m[11], "R5", "shared copy data", got_d, mem_m[11]);
        chk(wr_cnt == 0 && rd_cnt == 0, "R6", "clean downgrade no write", wr_cnt, 0);
        single_writer(11);
    endtask

    initial begin
        #1000000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int l = 0; l < NL; l++) begin
            mem_m[l] = 32'hA000_0000 + 32'(l);
            for (int k = 0; k < NC; k++) begin
                cst[k][l] = G_I;
                cd[k][l]  = '0;
            end
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_miss();
        t_read_dirty_owner();
        t_shared_hit();
        t_rfo_shared();
        t_read_after_transfer();
        t_rfo_miss_and_owned();
        t_owner_rerequest();
        t_clean_downgrade();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule